// File: doc/BRIEF.md
# Two-Bank DRAM Access and Refresh Sequencer

This block drives two DRAM banks that share one CAS strobe, one 11-bit multiplexed address bus and one set of output- and write-enable strobes, with a separate RAS strobe per bank. The banks are contiguous: bank 1 starts where bank 0 ends. A 2-bit size code selects a bank size of 128 KB, 512 KB, 2 MB or 8 MB. The size code sets which address bits go out as the column address, and which address bit picks the bank.

A requester raises `req_i` with a word address, a direction and byte enables, and holds them until `ack_o` pulses. It must drop `req_i` in the cycle of `ack_o`. Each access runs four cycles:

- **T1:** the row address is on the bus.
- **T2:** RAS of the chosen bank falls, the column address goes out, and the output or write enables assert.
- **T3:** CAS falls.
- **T4:** all strobes return high while `ack_o` pulses.

A refresh request pulse is held in a pending flag until it is served. A refresh cycle runs four cycles:

- CAS is low alone for one cycle.
- Both RAS lines and CAS are low for two cycles.
- One precharge cycle follows, in which `ref_ack_o` pulses.

Accesses and refreshes never overlap. A refresh pending in T1 of an access takes over the bus, and the access then resumes at T1. A system-reset or freeze input stops new refreshes from starting but never cuts a running one short.

Top module: `dram_bank_ctl`

## Requirements
- R1: The bank bit is address bit 17, 19, 21 or 23 for size code 0, 1, 2 or 3 (`page_size_i`). Bank 0 drives `ras_n_o[0]` low and bank 1 drives `ras_n_o[1]` low.
- R2: In T1, the first cycle after an access is accepted, `ma_o[k]` equals address bit k+1 for k = 0 to 10, and all strobes are high.
- R3: In T2 and T3, `ma_o[k]` equals address bit 9+code+k.
- R4: An access accepted at a clock edge has:
  - its RAS low in the 2nd and 3rd cycles after that edge;
  - CAS low in the 3rd cycle;
  - all strobes high and `ack_o` high in the 4th cycle;
  - idle in the 5th cycle when no request follows.
- R5: Enables during T2 and T3 of an access, with exactly one RAS low:
  - a read drives `oe_n_o` low with `we_n_o` at 11;
  - a write keeps `oe_n_o` high and drives `we_n_o[0]` low when `be_i[0]` is set (even byte) and `we_n_o[1]` low when `be_i[1]` is set (odd byte).
- R6: A refresh drives CAS low with both RAS high for one cycle, then CAS and both RAS low for two cycles, then everything high with `ref_ack_o` high for one cycle. `oe_n_o` and `we_n_o` stay inactive throughout.
- R7: Accesses and refreshes defer to each other:
  - a refresh request arriving in T2, T3 or T4 is served right after T4;
  - a request arriving during a refresh starts T1 in the cycle after the precharge cycle.
- R8: A refresh request seen in T1 starts a refresh in the next cycle. The held access then repeats T1 in the cycle after the precharge and completes normally.
- R9: While `sys_rst_i` or `freeze_i` is high, no refresh starts. A request made meanwhile stays pending and is served in the cycle after both inputs fall.
- R10: A refresh that has started completes all four cycles even if `sys_rst_i` or `freeze_i` rises during it.
- R11: While `rst_ni` is low, all strobes are high and both acknowledges are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| page_size_i | input | 2 | Bank size code, 0..3 |
| sys_rst_i | input | 1 | System reset mode, blocks new refreshes |
| freeze_i | input | 1 | Freeze or power-down mode, blocks new refreshes |
| ref_req_i | input | 1 | Refresh request, one or more cycles |
| ref_ack_o | output | 1 | Refresh completed, one-cycle pulse |
| req_i | input | 1 | Access request, held until ack |
| we_i | input | 1 | 1 for write, 0 for read |
| be_i | input | 2 | Byte enables, bit 0 even byte, bit 1 odd byte |
| addr_i | input | 23 | Byte address bits 23:1 |
| ack_o | output | 1 | Access completed, one-cycle pulse |
| ma_o | output | 11 | Multiplexed row/column address, bit k is address line k+1 |
| ras_n_o | output | 2 | Row strobes per bank, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| oe_n_o | output | 1 | Output enable, active low |
| we_n_o | output | 2 | Write enables per byte lane, active low |

## Verification
Accesses are issued under all four size codes with addresses whose bank bits alternate and whose row and column fields differ. A wrong column shift or a wrong bank bit therefore shows up on `ma_o` or `ras_n_o`. Reads and writes with each byte-enable pattern separate the output-enable path from each write lane.

Refresh requests are injected at distinct points:
- while idle;
- in T1 of an access;
- in T2 of an access;
- during a refresh, with an access arriving;
- under each blocking input.

Each of these points yields a different expected cycle trace. This separates refresh-first-in-T1 from plain deferral, and separates a dropped request from a held one. The mid-refresh blocking case confirms that a running refresh is never truncated.

// File: rtl/dram_bank_pkg.sv
package dram_bank_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_T1,
    ST_T2,
    ST_T3,
    ST_T4,
    ST_RCAS,
    ST_RRAS_A,
    ST_RRAS_B,
    ST_RPRE
  } seq_state_e;
endpackage

// File: rtl/dram_addr_map.sv
module dram_addr_map #(
  parameter int ADDR_W    = 24,
  parameter int MA_W      = 11,
  parameter int PS_W      = 2,
  parameter int ROW_LSB   = 1,
  parameter int COL_BASE  = 9,
  parameter int BANK_BASE = 17
) (
  input  logic [ADDR_W-1:1] addr_i,
  input  logic [PS_W-1:0]   ps_i,
  output logic [MA_W-1:0]   row_o,
  output logic [MA_W-1:0]   col_o,
  output logic              bank_o
);
  localparam int N_CODES = 1 << PS_W;

  logic [MA_W-1:0]    col_opt [N_CODES];
  logic [N_CODES-1:0] bank_opt;

  // one column window and one bank bit per size code
  for (genvar p = 0; p < N_CODES; p++) begin : g_code
    assign col_opt[p]  = addr_i[COL_BASE+p +: MA_W];
    assign bank_opt[p] = addr_i[BANK_BASE+2*p];
  end

  assign row_o  = addr_i[ROW_LSB +: MA_W];
  assign col_o  = col_opt[ps_i];
  assign bank_o = bank_opt[ps_i];
endmodule

// File: rtl/dram_ref_pend.sv
module dram_ref_pend (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_req_i,
  input  logic sys_rst_i,
  input  logic freeze_i,
  input  logic start_i,
  output logic go_o
);
  logic pend_q;
  logic want;

  assign want = pend_q | ref_req_i;
  assign go_o = want & ~(sys_rst_i | freeze_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= want & ~start_i;
  end
endmodule

// File: rtl/dram_seq.sv
module dram_seq
  import dram_bank_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_i,
  input  logic       ref_go_i,
  output seq_state_e state_o,
  output logic       acc_start_o,
  output logic       ref_start_o
);
  seq_state_e state_q, state_d;
  logic       held_q;
  seq_state_e pick_state;
  logic       pick_ref, pick_acc;

  // refresh wins over a new access at every decision point
  assign pick_ref   = ref_go_i;
  assign pick_acc   = ~ref_go_i & req_i;
  assign pick_state = pick_ref ? ST_RCAS : (pick_acc ? ST_T1 : ST_IDLE);

  always_comb begin
    state_d     = state_q;
    acc_start_o = 1'b0;
    ref_start_o = 1'b0;
    unique case (state_q)
      ST_IDLE, ST_T4: begin
        state_d     = pick_state;
        ref_start_o = pick_ref;
        acc_start_o = pick_acc;
      end
      ST_T1: begin
        if (ref_go_i) begin
          state_d     = ST_RCAS;
          ref_start_o = 1'b1;
        end else begin
          state_d = ST_T2;
        end
      end
      ST_T2:     state_d = ST_T3;
      ST_T3:     state_d = ST_T4;
      ST_RCAS:   state_d = ST_RRAS_A;
      ST_RRAS_A: state_d = ST_RRAS_B;
      ST_RRAS_B: state_d = ST_RPRE;
      ST_RPRE: begin
        if (held_q) begin
          state_d = ST_T1;
        end else begin
          state_d     = pick_state;
          ref_start_o = pick_ref;
          acc_start_o = pick_acc;
        end
      end
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      held_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (acc_start_o)          held_q <= 1'b1;
      else if (state_q == ST_T4) held_q <= 1'b0;
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/dram_bank_ctl.sv
module dram_bank_ctl
  import dram_bank_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int MA_W      = 11,
  parameter int PS_W      = 2,
  parameter int BE_W      = 2,
  parameter int NBANK     = 2,
  parameter int COL_BASE  = 9,
  parameter int BANK_BASE = 17
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PS_W-1:0]   page_size_i,
  input  logic              sys_rst_i,
  input  logic              freeze_i,
  input  logic              ref_req_i,
  output logic              ref_ack_o,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [BE_W-1:0]   be_i,
  input  logic [ADDR_W-1:1] addr_i,
  output logic              ack_o,
  output logic [MA_W-1:0]   ma_o,
  output logic [NBANK-1:0]  ras_n_o,
  output logic              cas_n_o,
  output logic              oe_n_o,
  output logic [BE_W-1:0]   we_n_o
);
  seq_state_e        state;
  logic              acc_start, ref_start, ref_go;
  logic [ADDR_W-1:1] addr_q;
  logic              we_q;
  logic [BE_W-1:0]   be_q;
  logic [PS_W-1:0]   ps_q;
  logic [MA_W-1:0]   row, col;
  logic              bank;
  logic              in_acc_strobe, in_ref_ras;

  dram_ref_pend u_pend (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ref_req_i (ref_req_i),
    .sys_rst_i (sys_rst_i),
    .freeze_i  (freeze_i),
    .start_i   (ref_start),
    .go_o      (ref_go)
  );

  dram_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .ref_go_i    (ref_go),
    .state_o     (state),
    .acc_start_o (acc_start),
    .ref_start_o (ref_start)
  );

  // access attributes held for the whole cycle, including a refresh detour
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      we_q   <= 1'b0;
      be_q   <= '0;
      ps_q   <= '0;
    end else if (acc_start) begin
      addr_q <= addr_i;
      we_q   <= we_i;
      be_q   <= be_i;
      ps_q   <= page_size_i;
    end
  end

  dram_addr_map #(
    .ADDR_W    (ADDR_W),
    .MA_W      (MA_W),
    .PS_W      (PS_W),
    .ROW_LSB   (1),
    .COL_BASE  (COL_BASE),
    .BANK_BASE (BANK_BASE)
  ) u_map (
    .addr_i (addr_q),
    .ps_i   (ps_q),
    .row_o  (row),
    .col_o  (col),
    .bank_o (bank)
  );

  assign in_acc_strobe = (state == ST_T2) || (state == ST_T3);
  assign in_ref_ras    = (state == ST_RRAS_A) || (state == ST_RRAS_B);

  always_comb begin
    ras_n_o = '1;
    if (in_acc_strobe)   ras_n_o[bank] = 1'b0;
    else if (in_ref_ras) ras_n_o = '0;
  end

  assign cas_n_o   = ~((state == ST_T3) || (state == ST_RCAS) || in_ref_ras);
  assign oe_n_o    = ~(in_acc_strobe & ~we_q);
  assign we_n_o    = (in_acc_strobe & we_q) ? ~be_q : '1;
  assign ma_o      = in_acc_strobe ? col : row;
  assign ack_o     = (state == ST_T4);
  assign ref_ack_o = (state == ST_RPRE);
endmodule

// File: rtl/dram_bank_ctl_chk.sv
module dram_bank_ctl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sys_rst_i,
  input logic       freeze_i,
  input logic       ack_o,
  input logic       ref_ack_o,
  input logic [1:0] ras_n_o,
  input logic       cas_n_o,
  input logic       oe_n_o,
  input logic [1:0] we_n_o
);
  p_both_ras_cbr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ras_n_o == 2'b00) |-> (!cas_n_o && oe_n_o && (we_n_o == 2'b11)));

  p_ref_ack_after_ras_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_ack_o |-> $past(ras_n_o == 2'b00));

  p_one_ras_rw_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!oe_n_o || (we_n_o != 2'b11)) |-> ($countones(ras_n_o) == 1));

  p_oe_we_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_n_o |-> (we_n_o == 2'b11));

  p_ack_after_cas_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> ($past(!cas_n_o) && cas_n_o && (ras_n_o == 2'b11)));

  p_no_overlap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ack_o && ref_ack_o));

  p_start_unblocked_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(cas_n_o) && (ras_n_o == 2'b11)) |-> $past(!sys_rst_i && !freeze_i));
endmodule

bind dram_bank_ctl dram_bank_ctl_chk u_chk (.*);

// File: tb/dram_bank_ctl_tb.sv
`timescale 1ns/1ps
module dram_bank_ctl_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  page_size_i = '0;
  logic        sys_rst_i = 1'b0;
  logic        freeze_i = 1'b0;
  logic        ref_req_i = 1'b0;
  logic        ref_ack_o;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [1:0]  be_i = '0;
  logic [23:1] addr_i = '0;
  logic        ack_o;
  logic [10:0] ma_o;
  logic [1:0]  ras_n_o;
  logic        cas_n_o;
  logic        oe_n_o;
  logic [1:0]  we_n_o;

  dram_bank_ctl u_dut (.*);

  always #10 clk_i = ~clk_i;

  int cyc = 0;
  always @(posedge clk_i) cyc <= cyc + 1;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct packed {
    int          cyc;
    logic [1:0]  ras;
    logic        cas;
    logic        oe;
    logic [1:0]  we;
    logic [10:0] ma;
    logic        mchk;
    logic        ack;
    logic        rack;
  } exp_t;

  exp_t  q[$];
  string tq[$];
  exp_t  mon_e;
  string mon_t;

  function automatic void push(int c, logic [1:0] ras, logic cas, logic oe, logic [1:0] we,
                               logic [10:0] ma, logic mchk, logic ack, logic rack, string tag);
    exp_t e;
    e.cyc = c; e.ras = ras; e.cas = cas; e.oe = oe; e.we = we;
    e.ma = ma; e.mchk = mchk; e.ack = ack; e.rack = rack;
    q.push_back(e);
    tq.push_back(tag);
  endfunction

  function automatic void exp_idle(int c, string tag);
    push(c, 2'b11, 1'b1, 1'b1, 2'b11, '0, 1'b0, 1'b0, 1'b0, tag);
  endfunction

  function automatic void exp_row(int c, logic [23:1] a);
    push(c, 2'b11, 1'b1, 1'b1, 2'b11, a[11:1], 1'b1, 1'b0, 1'b0, "R2 row in T1");
  endfunction

  function automatic void exp_access(int c, logic [23:1] a, logic w, logic [1:0] be, logic [1:0] ps);
    logic        bank;
    logic [10:0] col;
    logic [1:0]  ras_sel;
    logic [1:0]  wen;
    bank = a[17 + 2*ps];
    for (int k = 0; k < 11; k++) col[k] = a[9 + ps + k];
    ras_sel = bank ? 2'b01 : 2'b10;
    wen = w ? ~be : 2'b11;
    exp_row(c, a);
    push(c+1, ras_sel, 1'b1, w, wen, col, 1'b1, 1'b0, 1'b0, "R1 R3 R5 T2");
    push(c+2, ras_sel, 1'b0, w, wen, col, 1'b1, 1'b0, 1'b0, "R4 R5 T3");
    push(c+3, 2'b11, 1'b1, 1'b1, 2'b11, '0, 1'b0, 1'b1, 1'b0, "R4 ack in T4");
  endfunction

  function automatic void exp_ref(int c, string tag);
    push(c,   2'b11, 1'b0, 1'b1, 2'b11, '0, 1'b0, 1'b0, 1'b0, tag);
    push(c+1, 2'b00, 1'b0, 1'b1, 2'b11, '0, 1'b0, 1'b0, 1'b0, tag);
    push(c+2, 2'b00, 1'b0, 1'b1, 2'b11, '0, 1'b0, 1'b0, 1'b0, tag);
    push(c+3, 2'b11, 1'b1, 1'b1, 2'b11, '0, 1'b0, 1'b0, 1'b1, tag);
  endfunction

  // monitor: compares design outputs against queued expectations
  always @(negedge clk_i) begin
    if (rst_ni) begin
      while (q.size() > 0 && q[0].cyc <= cyc) begin
        mon_e = q.pop_front();
        mon_t = tq.pop_front();
        checks++;
        if (mon_e.cyc < cyc) begin
          failures++;
          $display("FAIL %s: got no sample at cycle %0d, expected one (now %0d)", mon_t, mon_e.cyc, cyc);
        end else if (ras_n_o !== mon_e.ras || cas_n_o !== mon_e.cas || oe_n_o !== mon_e.oe ||
                     we_n_o !== mon_e.we || ack_o !== mon_e.ack || ref_ack_o !== mon_e.rack ||
                     (mon_e.mchk && ma_o !== mon_e.ma)) begin
          failures++;
          $display("FAIL %s cyc %0d: got ras=%b cas=%b oe=%b we=%b ma=%h ack=%b rack=%b expected ras=%b cas=%b oe=%b we=%b ma=%h(chk %b) ack=%b rack=%b",
                   mon_t, cyc, ras_n_o, cas_n_o, oe_n_o, we_n_o, ma_o, ack_o, ref_ack_o,
                   mon_e.ras, mon_e.cas, mon_e.oe, mon_e.we, mon_e.ma, mon_e.mchk, mon_e.ack, mon_e.rack);
        end
      end
    end
  end

  task automatic wait_to(int n);
    while (cyc < n) @(negedge clk_i);
  endtask

  task automatic drive_req(logic [23:1] a, logic w, logic [1:0] be, logic [1:0] ps);
    addr_i = a; we_i = w; be_i = be; page_size_i = ps; req_i = 1'b1;
  endtask

  task automatic run_access(logic [23:1] a, logic w, logic [1:0] be, logic [1:0] ps);
    int c;
    c = cyc;
    drive_req(a, w, be, ps);
    exp_access(c+1, a, w, be, ps);
    exp_idle(c+5, "R4 idle after ack");
    wait_to(c+4);
    req_i = 1'b0;
    wait_to(c+5);
  endtask

  initial begin
    int c;
    repeat (2) @(negedge clk_i);
    checks++;
    if (ras_n_o !== 2'b11 || cas_n_o !== 1'b1 || oe_n_o !== 1'b1 || we_n_o !== 2'b11 ||
        ack_o !== 1'b0 || ref_ack_o !== 1'b0) begin
      failures++;
      $display("FAIL R11 reset: got ras=%b cas=%b oe=%b we=%b ack=%b rack=%b expected 11 1 1 11 0 0",
               ras_n_o, cas_n_o, oe_n_o, we_n_o, ack_o, ref_ack_o);
    end
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 R2 R3 R5: every size code, both banks, read and all write lane patterns
    run_access(23'h01AD2F, 1'b0, 2'b00, 2'd0);
    run_access(23'h0B52E1, 1'b1, 2'b01, 2'd1);
    run_access(23'h2F891A, 1'b1, 2'b10, 2'd2);
    run_access(23'h63C567, 1'b1, 2'b11, 2'd3);
    run_access(23'h1BFFFF, 1'b0, 2'b00, 2'd3);
    run_access(23'h00AAAA, 1'b0, 2'b00, 2'd1);

    // R6: refresh from idle
    c = cyc;
    ref_req_i = 1'b1;
    exp_ref(c+1, "R6 refresh idle");
    exp_idle(c+5, "R6 idle after refresh");
    wait_to(c+1); ref_req_i = 1'b0;
    wait_to(c+5);

    // R8: refresh request during T1 goes first
    c = cyc;
    drive_req(23'h3A5C3C, 1'b0, 2'b00, 2'd1);
    exp_row(c+1, 23'h3A5C3C);
    exp_ref(c+2, "R8 refresh before access");
    exp_access(c+6, 23'h3A5C3C, 1'b0, 2'b00, 2'd1);
    exp_idle(c+10, "R8 idle after access");
    wait_to(c+1); ref_req_i = 1'b1;
    wait_to(c+2); ref_req_i = 1'b0;
    wait_to(c+9); req_i = 1'b0;
    wait_to(c+10);

    // R7: refresh request during T2 is deferred until after T4
    c = cyc;
    drive_req(23'h15F00D, 1'b1, 2'b11, 2'd2);
    exp_access(c+1, 23'h15F00D, 1'b1, 2'b11, 2'd2);
    exp_ref(c+5, "R7 deferred refresh");
    exp_idle(c+9, "R7 idle");
    wait_to(c+2); ref_req_i = 1'b1;
    wait_to(c+3); ref_req_i = 1'b0;
    wait_to(c+4); req_i = 1'b0;
    wait_to(c+9);

    // R7: access arriving during refresh waits for the precharge
    c = cyc;
    ref_req_i = 1'b1;
    exp_ref(c+1, "R7 refresh holds access");
    exp_access(c+5, 23'h4E1234, 1'b0, 2'b00, 2'd0);
    exp_idle(c+9, "R7 idle");
    wait_to(c+1); ref_req_i = 1'b0;
    wait_to(c+2); drive_req(23'h4E1234, 1'b0, 2'b00, 2'd0);
    wait_to(c+8); req_i = 1'b0;
    wait_to(c+9);

    // R9: freeze blocks start, request kept pending
    c = cyc;
    freeze_i = 1'b1; ref_req_i = 1'b1;
    exp_idle(c+1, "R9 freeze blocks");
    exp_idle(c+2, "R9 freeze blocks");
    exp_idle(c+3, "R9 freeze blocks");
    wait_to(c+1); ref_req_i = 1'b0;
    wait_to(c+3); freeze_i = 1'b0;
    exp_ref(c+4, "R9 served after freeze");
    exp_idle(c+8, "R9 idle");
    wait_to(c+8);

    // R9: system reset mode blocks start
    c = cyc;
    sys_rst_i = 1'b1; ref_req_i = 1'b1;
    exp_idle(c+1, "R9 sys reset blocks");
    exp_idle(c+2, "R9 sys reset blocks");
    wait_to(c+1); ref_req_i = 1'b0;
    wait_to(c+2); sys_rst_i = 1'b0;
    exp_ref(c+3, "R9 served after sys reset");
    exp_idle(c+7, "R9 idle");
    wait_to(c+7);

    // R10: refresh in flight completes when blocking inputs rise
    c = cyc;
    ref_req_i = 1'b1;
    exp_ref(c+1, "R10 refresh completes");
    wait_to(c+1); ref_req_i = 1'b0; sys_rst_i = 1'b1; freeze_i = 1'b1;
    wait_to(c+2); ref_req_i = 1'b1;
    exp_idle(c+5, "R9 blocked after R10");
    exp_idle(c+6, "R9 blocked after R10");
    wait_to(c+3); ref_req_i = 1'b0;
    wait_to(c+6); sys_rst_i = 1'b0; freeze_i = 1'b0;
    exp_ref(c+7, "R9 pending served");
    exp_idle(c+11, "R9 idle");
    wait_to(c+11);

    repeat (3) @(negedge clk_i);
    if (q.size() != 0) begin
      checks++;
      failures++;
      $display("FAIL all: got %0d unchecked items, expected 0", q.size());
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL all: watchdog got still running, expected finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule